// File: doc/BRIEF.md
# Configurable Time-Slot Memory Arbiter

This block lets up to sixteen processor cores share one on-chip memory. Exactly one core owns each clock, chosen by a slot counter that walks through the cores in index order and then starts again. Each core presents an address, a write flag, sixteen byte-lane enables and a 128-bit write word. A core that wants an access raises its request and keeps it raised with stable fields until it sees its grant. The access happens on the clock edge that ends the granted cycle. Read data comes back on the next cycle, together with a one-cycle valid pulse for that core.

A run-time share setting chooses how many cores take part in the rotation: 1, 2, 4, 8 or 16. With fewer sharers, the slot counter wraps sooner, so every remaining core gets its turn more often. Cores outside the chosen range are never served. A new setting is held as pending and only takes effect when the counter returns to zero, so a rotation that has started always finishes with the old setting. For every core the block also gives the number of clocks until that core's next slot, so that software on the core can line its accesses up with its slot.

Top module: `time_slot_arbiter`

## Requirements
- R1: After reset, all 16 cores share the rotation and the slot counter is 0. No grant and no read-valid are active until a request is made, and core 0 owns the first slot.
- R2: With 16 sharers, core k is granted only in cycles where the slot counter equals k. A core that requests without a break is granted exactly once every 16 clocks.
- R3: The share code `mode_val` sets the number of sharers to 2^code: 0→1, 1→2, 2→4, 3→8, 4→16. Codes 5 to 7 select 16. With N sharers, an active core that requests without a break is granted once every N clocks.
- R4: A core whose index is N or greater is never granted while N sharers are in force.
- R5: A code written with `mode_wr` is held and takes effect on the edge where the slot counter wraps to 0. Until then, the current rotation keeps its old order and length.
- R6: A request made outside its slot is held off until the requesting core's own slot, and at most one grant is active in any cycle.
- R7: On a granted write, byte lane i (bits 8i+7..8i) of the addressed word is updated only when enable bit i is set. All other lanes keep their contents.
- R8: A granted read drives `rd_data` with the addressed word one clock later and pulses `rd_valid` for the granted core only, for one cycle. A write produces no read-valid.
- R9: `slot_dist` field k (5 bits, at bits 5k+4..5k) gives (k − counter) mod N for an active core, where 0 means the current cycle is its slot. The field reads 31 for a core outside the rotation.
- R10: A slot whose owner does not request stays unused. No other core is granted in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Strobe that loads the pending share code |
| mode_val | input | 3 | Share code (log2 of the sharer count) |
| req | input | 16 | Access request, one bit per core |
| req_we | input | 16 | Write flag per core (1 = write) |
| req_addr | input | 96 | Word address, 6 bits per core, core k at bits 6k+5..6k |
| req_be | input | 256 | Byte-lane enables, 16 per core |
| req_wdata | input | 2048 | Write word, 128 bits per core |
| grant | output | 16 | Access performed at the end of this cycle |
| rd_valid | output | 16 | Read data valid for this core |
| rd_data | output | 128 | Shared read data return |
| slot_dist | output | 80 | Clocks to each core's next slot, 5 bits per core |

## Verification
The bench tracks the slot counter and share setting from the requirements and compares the grant vector and every slot-distance field on each cycle while all cores request. A scheduler that applied a new share code at once, instead of at the wrap, would cut off cores 6 to 15 in the rotation that was running. The bench catches this by watching core 10 after a mid-rotation change. It measures grant spacing at several share counts, so a wrong wrap point shows up as a wrong period, and a core above the limit that gets a grant is also reported. Byte-enable merges and read return timing are checked on data. A design that reassigned idle slots, or that pulsed read-valid on writes, would break the per-cycle grant comparison or the read-valid comparison.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  // Limit a requested log2 sharer count to the largest the block supports.
  function automatic int clamp_log(input int code, input int log_max);
    return (code > log_max) ? log_max : code;
  endfunction

  // Clocks until a core's next slot; -1 when the core is out of the rotation.
  function automatic int slot_gap(input int core, input int cnt, input int share);
    if (core >= share) return -1;
    return (core - cnt + share) % share;
  endfunction

endpackage

// File: rtl/tsa_slot_sched.sv
module tsa_slot_sched #(
  parameter int NCORE = 16,
  parameter int CW    = $clog2(NCORE),
  parameter int LW    = $clog2(CW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wr,
  input  logic [LW-1:0] mode_val,
  output logic [CW-1:0] cnt,
  output logic [LW-1:0] share_log,
  output logic [CW:0]   share_n,
  output logic          wrap
);
  import tsa_pkg::*;

  logic [LW-1:0] pend_log;

  assign share_n = (CW+1)'(1) << share_log;
  assign wrap    = ({1'b0, cnt} == share_n - (CW+1)'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      share_log <= LW'(CW);
      pend_log  <= LW'(CW);
    end else begin
      if (mode_wr) pend_log <= LW'(clamp_log(int'(mode_val), CW));
      if (wrap) begin
        cnt       <= '0;
        share_log <= pend_log;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R5
  mode_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $stable(share_log));

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} < share_n);

endmodule

// File: rtl/tsa_grant_mux.sv
module tsa_grant_mux #(
  parameter int NCORE  = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 128,
  parameter int CW     = $clog2(NCORE),
  parameter int DW     = CW + 1,
  parameter int LANES  = DATA_W / 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CW-1:0]            cnt,
  input  logic [CW:0]              share_n,
  input  logic [NCORE-1:0]         req,
  input  logic [NCORE-1:0]         req_we,
  input  logic [NCORE*ADDR_W-1:0]  req_addr,
  input  logic [NCORE*LANES-1:0]   req_be,
  input  logic [NCORE*DATA_W-1:0]  req_wdata,
  output logic [NCORE-1:0]         grant,
  output logic                     acc_en,
  output logic                     acc_we,
  output logic [ADDR_W-1:0]        acc_addr,
  output logic [LANES-1:0]         acc_be,
  output logic [DATA_W-1:0]        acc_wdata,
  output logic [CW-1:0]            acc_core,
  output logic [NCORE*DW-1:0]      slot_dist
);
  import tsa_pkg::*;

  // Slot owner's request fields.
  assign acc_core  = cnt;
  assign acc_en    = req[cnt];
  assign acc_we    = req_we[cnt];
  assign acc_addr  = req_addr[cnt*ADDR_W +: ADDR_W];
  assign acc_be    = req_be[cnt*LANES +: LANES];
  assign acc_wdata = req_wdata[cnt*DATA_W +: DATA_W];

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    logic owner;
    int   gap;
    assign owner = (cnt == CW'(k));
    assign grant[k] = owner & req[k];
    assign gap = slot_gap(k, int'(cnt), int'(share_n));
    assign slot_dist[k*DW +: DW] = (gap < 0) ? {DW{1'b1}} : DW'(gap);

    // R4
    no_grant_above_share_chk: assert property (@(posedge clk) disable iff (rst)
      grant[k] |-> ((CW+1)'(k) < share_n));
  end

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R10
  idle_slot_unused_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);

endmodule

// File: rtl/tsa_mem_bank.sv
module tsa_mem_bank #(
  parameter int NCORE  = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 128,
  parameter int CW     = $clog2(NCORE),
  parameter int LANES  = DATA_W / 8,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LANES-1:0]  acc_be,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [CW-1:0]     acc_core,
  output logic [NCORE-1:0]  rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              rd_go;
  logic              wr_go;

  assign rd_go = acc_en & ~acc_we;
  assign wr_go = acc_en &  acc_we;

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int l = 0; l < LANES; l++) begin
        if (acc_be[l]) mem[acc_addr][l*8 +: 8] <= acc_wdata[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_go) rd_data <= mem[acc_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= '0;
    else     rd_valid <= rd_go ? (NCORE'(1) << acc_core) : '0;
  end

  // R8
  rd_valid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid != '0) |-> $past(rd_go));

  // R8
  rd_valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_valid));

endmodule

// File: rtl/time_slot_arbiter.sv
module time_slot_arbiter #(
  parameter int NCORE  = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 128,
  parameter int MODE_W = $clog2($clog2(NCORE) + 1),
  parameter int DIST_W = $clog2(NCORE) + 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            mode_wr,
  input  logic [MODE_W-1:0]               mode_val,
  input  logic [NCORE-1:0]                req,
  input  logic [NCORE-1:0]                req_we,
  input  logic [NCORE*ADDR_W-1:0]         req_addr,
  input  logic [NCORE*(DATA_W/8)-1:0]     req_be,
  input  logic [NCORE*DATA_W-1:0]         req_wdata,
  output logic [NCORE-1:0]                grant,
  output logic [NCORE-1:0]                rd_valid,
  output logic [DATA_W-1:0]               rd_data,
  output logic [NCORE*DIST_W-1:0]         slot_dist
);
  localparam int CW    = $clog2(NCORE);
  localparam int LANES = DATA_W / 8;

  logic [CW-1:0]     cnt;
  logic [MODE_W-1:0] share_log;
  logic [CW:0]       share_n;
  logic              wrap;
  logic              acc_en, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_be;
  logic [DATA_W-1:0] acc_wdata;
  logic [CW-1:0]     acc_core;

  tsa_slot_sched #(.NCORE(NCORE), .CW(CW), .LW(MODE_W)) u_sched (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
    .cnt(cnt), .share_log(share_log), .share_n(share_n), .wrap(wrap)
  );

  tsa_grant_mux #(.NCORE(NCORE), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .CW(CW), .DW(DIST_W), .LANES(LANES)) u_mux (
    .clk(clk), .rst(rst), .cnt(cnt), .share_n(share_n),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .grant(grant), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_core(acc_core), .slot_dist(slot_dist)
  );

  tsa_mem_bank #(.NCORE(NCORE), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .CW(CW), .LANES(LANES)) u_mem (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_core(acc_core), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R2
  grant_matches_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> grant[cnt]);

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wrap) |-> (cnt == '0));

endmodule

// File: tb/tb_time_slot_arbiter.sv
module tb_time_slot_arbiter;
  localparam int N  = 16;
  localparam int AW = 6;
  localparam int DWD = 128;
  localparam int LN = DWD / 8;
  localparam int SW = 5;

  logic clk = 0;
  logic rst = 1;
  logic mode_wr = 0;
  logic [2:0] mode_val = '0;
  logic [N-1:0] req = '0, req_we = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*LN-1:0] req_be = '0;
  logic [N*DWD-1:0] req_wdata = '0;
  logic [N-1:0] grant, rd_valid;
  logic [DWD-1:0] rd_data;
  logic [N*SW-1:0] slot_dist;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;

  // Bench model of the rotation, written from R1, R3 and R5.
  int b_cnt = 0, b_log = 4, b_pend = 4;

  always #2.5 clk = ~clk;

  time_slot_arbiter dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .grant(grant), .rd_valid(rd_valid),
    .rd_data(rd_data), .slot_dist(slot_dist)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      b_cnt <= 0; b_log <= 4; b_pend <= 4;
    end else begin
      if (mode_wr) b_pend <= (int'(mode_val) > 4) ? 4 : int'(mode_val);
      if (b_cnt == (1 << b_log) - 1) begin
        b_cnt <= 0; b_log <= b_pend;
      end else b_cnt <= b_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Grant vector and all distance fields against the model (R2 R3 R4 R6 R9 R10).
  task automatic check_cycle();
    int sh;
    logic [N-1:0] eg;
    logic [N*SW-1:0] ed;
    sh = 1 << b_log;
    eg = (b_cnt < sh) ? (req & (N'(1) << b_cnt)) : '0;
    check(grant == eg, "R6/R10", "grant vector", 128'(grant), 128'(eg));
    for (int k = 0; k < N; k++)
      ed[k*SW +: SW] = (k < sh) ? SW'((k - b_cnt + sh) % sh) : 5'd31;
    check(slot_dist == ed, "R9", "slot_dist", 128'(slot_dist), 128'(ed));
  endtask

  task automatic set_mode(input int code);
    @(negedge clk);
    mode_wr = 1; mode_val = 3'(code);
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic wait_mode(input int lg);
    int guard = 0;
    while (!(b_log == lg && b_cnt == 0) && guard < 64) begin
      @(negedge clk); guard++;
    end
  endtask

  // One access by core k; returns read data when a read.
  task automatic access(input int k, input bit we, input int addr,
                        input logic [LN-1:0] be, input logic [DWD-1:0] d,
                        output logic [DWD-1:0] rdata);
    int waited = 0;
    @(negedge clk);
    req[k] = 1; req_we[k] = we;
    req_addr[k*AW +: AW] = AW'(addr);
    req_be[k*LN +: LN] = be;
    req_wdata[k*DWD +: DWD] = d;
    #1;
    while (!grant[k] && waited < 40) begin
      check(grant == '0 || b_cnt != k, "R6", "held request", 128'(grant), 128'(0));
      @(negedge clk); #1; waited++;
    end
    check(b_cnt == k, "R6", "grant in own slot", 128'(b_cnt), 128'(k));
    @(negedge clk);
    req[k] = 0;
    if (we) begin
      check(rd_valid == '0, "R8", "no valid on write", 128'(rd_valid), 128'(0));
    end else begin
      check(rd_valid == (N'(1) << k), "R8", "read valid pulse",
            128'(rd_valid), 128'(N'(1) << k));
    end
    rdata = rd_data;
    @(negedge clk);
    check(rd_valid == '0, "R8", "valid one cycle", 128'(rd_valid), 128'(0));
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(grant == '0, "R1", "grant after reset", 128'(grant), 128'(0));
    check(rd_valid == '0, "R1", "rd_valid after reset", 128'(rd_valid), 128'(0));
    check(slot_dist[0 +: SW] == 0, "R1", "core0 owns first slot",
          128'(slot_dist[0 +: SW]), 128'(0));
    check(slot_dist[15*SW +: SW] == 15, "R9", "core15 distance",
          128'(slot_dist[15*SW +: SW]), 128'(15));
  endtask

  task automatic t_data();
    logic [DWD-1:0] r, p1, p2, exp;
    p1 = {4{32'hA5C3_1E70}} ^ 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    p2 = {16{8'h5A}};
    access(3, 1, 5, '1, p1, r);
    access(9, 0, 5, '0, '0, r);
    check(r == p1, "R8", "read back full word", r, p1);
    access(3, 1, 5, 16'h00F0, p2, r);
    exp = p1;
    for (int l = 4; l < 8; l++) exp[l*8 +: 8] = 8'h5A;
    access(15, 0, 5, '0, '0, r);
    check(r == exp, "R7", "byte-lane merge", r, exp);
    access(0, 1, 9, 16'h8001, {DWD{1'b1}}, r);
    access(0, 0, 9, '0, '0, r);
    check(r[7:0] == 8'hFF && r[127:120] == 8'hFF, "R7", "edge lanes written",
          128'(r), 128'hFF);
  endtask

  task automatic t_period(input int code, input int lg);
    int sh, last[N], cnt_hi;
    logic [N-1:0] prev;
    sh = 1 << lg;
    set_mode(code);
    wait_mode(lg);
    for (int k = 0; k < N; k++) last[k] = -1;
    cnt_hi = 0; prev = '0;
    req = '1; req_we = '0; req_addr = '0;
    for (int c = 0; c < 3 * sh + 4; c++) begin
      #1;
      check_cycle();
      if (c > 0) check(rd_valid == prev, "R8", "read valid after grant",
                       128'(rd_valid), 128'(prev));
      for (int k = 0; k < N; k++) if (grant[k]) begin
        if (k >= sh) cnt_hi++;
        if (last[k] >= 0)
          check(c - last[k] == sh, (lg == 4) ? "R2" : "R3", "grant period",
                128'(c - last[k]), 128'(sh));
        last[k] = c;
      end
      prev = grant;
      @(negedge clk);
    end
    req = '0;
    check(cnt_hi == 0, "R4", "no grant above share", 128'(cnt_hi), 128'(0));
  endtask

  task automatic t_switch();
    bit saw10 = 0;
    set_mode(4);
    wait_mode(4);
    req = '1; req_we = '0;
    while (b_cnt != 5) @(negedge clk);
    mode_wr = 1; mode_val = 3'd1;
    for (int c = 0; c < 30; c++) begin
      #1;
      check_cycle();
      if (grant[10] && b_log == 4) saw10 = 1;
      @(negedge clk);
      mode_wr = 0;
    end
    req = '0;
    check(saw10, "R5", "old rotation finished", 128'(saw10), 128'(1));
    check(b_log == 1, "R5", "new share in force", 128'(b_log), 128'(1));
  endtask

  task automatic t_idle();
    set_mode(3);
    wait_mode(3);
    req = '0; req[2] = 1; req_we = '0;
    for (int c = 0; c < 20; c++) begin
      #1;
      check_cycle();
      if (b_cnt == 3)
        check(grant == '0, "R10", "idle slot unused", 128'(grant), 128'(0));
      @(negedge clk);
    end
    req = '0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_data();
        t_period(4, 4);
        t_period(3, 3);
        t_period(1, 1);
        t_period(0, 0);
        t_period(7, 4);
        t_switch();
        t_idle();
      end
      begin
        while (cyc < 150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule